// File: doc/BRIEF.md
# Bit-Addressed Interrupt Input Port

This block gives a processor single-bit access to sixteen input-only lines and merges their requests into one interrupt. The processor names a bit by a base address plus an offset. Reading a bit always returns the synchronized level of that line. Writing a bit never drives the line. A write of one arms that line's interrupt mask bit, and a write of zero disarms it. A multi-bit load returns a run of consecutive lines in one word.

Each line is active low. The interrupt output is raised while any armed line is held low. Reading a line leaves both the line and any pending request unchanged. A request clears only when its source releases the line, or when software disarms the mask. Line 2 is the typical case: a video controller's frame interrupt arrives there. Software can poll that line with its mask cleared and still see a 0 whenever a frame has ended.

Top module: `bitport_irq`

## Requirements
- R1: The effective bit address is (base_i + offset_i) modulo 2^ADDR_W. Addresses 0 to NUM_LINES-1 select lines. At any higher address a read returns 0 and a write changes no mask bit. With the defaults, base 30 plus offset 4 selects line 2, and address 18 selects nothing.
- R2: A set_one_i pulse at line address k sets mask bit k at the next rising edge, and a set_zero_i pulse clears it. When both are high in the same cycle, the bit is set.
- R3: Reset clears every mask bit, so irq_o stays low after reset even when all lines are held low.
- R4: Each line passes through two flops. A level change on line_n_i becomes visible on bit_o, word_o and irq_o after the second rising edge following the change. The synchronizer resets to all ones, which is the idle level.
- R5: bit_o is the synchronized level of the addressed line whether its mask bit is 0 or 1. Reading changes neither the mask nor irq_o.
- R6: irq_o is 1 exactly when at least one line has mask bit 1 and synchronized level 0. A low line whose mask bit is 0 has no effect on irq_o.
- R7: A raised irq_o stays high as long as its source holds the line low, however often the line is read. It falls two edges after the line returns high, or one edge after the mask bit is cleared.
- R8: Bit j of word_o is the level of line (effective address + j) when j is below the count and that line exists, and 0 otherwise. The count is ld_count_i, where a value of 0 means NUM_LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_n_i | input | NUM_LINES | Asynchronous active-low request lines |
| base_i | input | ADDR_W | Base bit address |
| offset_i | input | ADDR_W | Offset added to the base |
| set_one_i | input | 1 | Write 1 to the addressed bit (arm its mask) |
| set_zero_i | input | 1 | Write 0 to the addressed bit (disarm its mask) |
| ld_count_i | input | IDX_W | Number of bits in a multi-bit load, 0 meaning all |
| bit_o | output | 1 | Level of the addressed line |
| word_o | output | NUM_LINES | Consecutive line levels from the addressed bit upward |
| irq_o | output | 1 | Combined interrupt request, active high |

## Verification
The bench builds the block with its defaults: sixteen lines and a 5-bit address space. These values place addresses 16 to 31 within reach. At those addresses a read must return 0 and a write must be ignored. Address 18 catches any decode that drops the top address bit. The 5-bit modulo sum lets a base of 30 with an offset of 4 wrap onto line 2. Loads that start near line 15 show the zero fill beyond the last line.

// File: rtl/bitport_irq.sv
module bitport_irq #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LINES-1:0]              line_n_i,
  input  logic [ADDR_W-1:0]                 base_i,
  input  logic [ADDR_W-1:0]                 offset_i,
  input  logic                              set_one_i,
  input  logic                              set_zero_i,
  input  logic [$clog2(NUM_LINES)-1:0]      ld_count_i,
  output logic                              bit_o,
  output logic [NUM_LINES-1:0]              word_o,
  output logic                              irq_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [ADDR_W:0] LINES_A = NUM_LINES[ADDR_W:0];
  localparam logic [IDX_W:0]  FULL_C  = NUM_LINES[IDX_W:0];

  logic [NUM_LINES-1:0] meta_q, sync_q, mask_q;
  logic [ADDR_W-1:0]    eff;
  logic [IDX_W-1:0]     idx;
  logic                 in_rng;
  logic [IDX_W:0]       cnt;

  assign eff    = base_i + offset_i;
  assign idx    = eff[IDX_W-1:0];
  assign in_rng = ({1'b0, eff} < LINES_A);
  assign cnt    = (ld_count_i == '0) ? FULL_C : {1'b0, ld_count_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= line_n_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (in_rng && set_one_i)
      mask_q[idx] <= 1'b1;
    else if (in_rng && set_zero_i)
      mask_q[idx] <= 1'b0;
  end

  assign bit_o = in_rng ? sync_q[idx] : 1'b0;
  assign irq_o = |(~sync_q & mask_q);

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_word
    logic [ADDR_W:0] pos;
    assign pos = {1'b0, eff} + (ADDR_W+1)'(j);
    assign word_o[j] = (pos < LINES_A) && ((IDX_W+1)'(j) < cnt) && sync_q[pos[IDX_W-1:0]];
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= '0;
    else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
  end

  a_r2_set_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && set_one_i) |=> mask_q[$past(idx)]);

  a_r2_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && set_zero_i && !set_one_i) |=> !mask_q[$past(idx)]);

  a_r1_r5_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rng || (!set_one_i && !set_zero_i)) |=> $stable(mask_q));

  a_r4_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (sync_q == $past(line_n_i, 2)));

  a_r3_r6_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);
endmodule

// File: tb/bitport_irq_tb.sv
module bitport_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] line_n = 16'h0000;
  logic [4:0]  base = '0, offset = '0;
  logic        s1 = 1'b0, s0 = 1'b0;
  logic [3:0]  cnt = '0;
  logic        bit_o, irq_o;
  logic [15:0] word_o;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bitport_irq dut_i (.clk(clk), .rst_n(rst_n), .line_n_i(line_n), .base_i(base),
    .offset_i(offset), .set_one_i(s1), .set_zero_i(s0), .ld_count_i(cnt),
    .bit_o(bit_o), .word_o(word_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] b, input logic [4:0] o, input logic one, input logic zero);
    base = b; offset = o; s1 = one; s0 = zero;
    edges(1);
    s1 = 1'b0; s0 = 1'b0;
  endtask

  task automatic rd(input logic [4:0] b, input logic [4:0] o);
    base = b; offset = o; #1;
  endtask

  // lines, base, offset, expected bit, expected irq (mask armed on lines 5 and 9)
  localparam logic [27:0] VEC [7] = '{
    {16'hFFFF, 5'd0,  5'd5, 1'b1, 1'b0},
    {16'hFFDF, 5'd3,  5'd2, 1'b0, 1'b1},
    {16'hFDFF, 5'd9,  5'd0, 1'b0, 1'b1},
    {16'h0000, 5'd15, 5'd0, 1'b0, 1'b1},
    {16'hFF7F, 5'd7,  5'd0, 1'b0, 1'b0},
    {16'h7FFF, 5'd10, 5'd5, 1'b0, 1'b0},
    {16'h8000, 5'd15, 5'd0, 1'b1, 1'b1}
  };

  initial begin
    fork
      begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    join_none

    edges(2);
    rst_n = 1'b1;
    edges(3);
    chk("R3 no irq after reset with lines low", {15'd0, irq_o}, 16'd0);
    rd(0, 2);
    chk("R5 read low line with mask clear", {15'd0, bit_o}, 16'd0);

    line_n = 16'hFFFF;
    edges(2);
    wr(0, 2, 1, 0);
    chk("R6 armed line high gives no irq", {15'd0, irq_o}, 16'd0);
    line_n[2] = 1'b0;
    edges(1);
    chk("R4 one edge not yet visible", {15'd0, irq_o}, 16'd0);
    edges(1);
    chk("R4 R6 visible after second edge", {15'd0, irq_o}, 16'd1);
    for (int i = 0; i < 4; i++) begin
      rd(0, 2);
      edges(1);
    end
    chk("R7 irq held through repeated reads", {15'd0, irq_o}, 16'd1);
    chk("R5 read returns low line", {15'd0, bit_o}, 16'd0);

    wr(0, 2, 0, 1);
    chk("R2 clear disarms irq", {15'd0, irq_o}, 16'd0);
    rd(0, 2);
    chk("R5 masked line still readable", {15'd0, bit_o}, 16'd0);
    wr(1, 1, 1, 1);
    chk("R2 simultaneous write sets", {15'd0, irq_o}, 16'd1);
    line_n[2] = 1'b1;
    edges(1);
    chk("R7 irq holds one edge after release", {15'd0, irq_o}, 16'd1);
    edges(1);
    chk("R7 irq drops after release", {15'd0, irq_o}, 16'd0);

    wr(30, 4, 0, 1);
    line_n[2] = 1'b0;
    edges(2);
    chk("R1 wrapped address cleared line 2", {15'd0, irq_o}, 16'd0);
    wr(18, 0, 1, 0);
    chk("R1 write above lines ignored", {15'd0, irq_o}, 16'd0);
    rd(30, 4);
    chk("R1 wrapped read of line 2", {15'd0, bit_o}, 16'd0);
    line_n = 16'hFFFF;
    edges(2);
    rd(20, 0);
    chk("R1 read above lines is zero", {15'd0, bit_o}, 16'd0);

    wr(5, 0, 1, 0);
    wr(4, 5, 1, 0);
    for (int v = 0; v < 7; v++) begin
      line_n = VEC[v][27:12];
      edges(2);
      rd(VEC[v][11:7], VEC[v][6:2]);
      chk($sformatf("R5 vector %0d bit", v), {15'd0, bit_o}, {15'd0, VEC[v][1]});
      chk($sformatf("R6 vector %0d irq", v), {15'd0, irq_o}, {15'd0, VEC[v][0]});
    end

    line_n = 16'hA5C3;
    edges(2);
    cnt = 4'd0; rd(0, 0);
    chk("R8 full load", word_o, 16'hA5C3);
    cnt = 4'd4; rd(4, 0);
    chk("R8 four bits from line 4", word_o, 16'h000C);
    cnt = 4'd8; rd(12, 0);
    chk("R8 load past last line zero filled", word_o, 16'h000A);
    cnt = 4'd1; rd(14, 1);
    chk("R8 single bit from line 15", word_o, 16'h0001);
    cnt = 4'd0; rd(20, 0);
    chk("R8 load above lines", word_o, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule